// File: doc/BRIEF.md
# Ping-Pong Framebuffer Fetch Engine

This block reads pixel data from memory for a display raster engine. It issues read bursts against one of two framebuffer descriptors. Each descriptor holds a start address and an inclusive end address, which is the last byte of the buffer. The returned words go into an internal pixel FIFO, and the raster side drains that FIFO.

In alternating mode the engine fetches buffer 0, then buffer 1, then buffer 0 again, and so on. It raises a separate end-of-buffer event for each buffer, so software knows which descriptor is now idle and can be reloaded. In single mode only buffer 0 is fetched, over and over.

The burst size is programmed as a power-of-two code. A threshold code sets how full the FIFO must be before pixels are offered to the consumer. The consumer can starve the FIFO; when it does, the block reports an underflow event.

Top module: `pingpong_fb_fetch`

## Requirements
- R1: While reset is held, and after reset while `fetch_en` is low, `mrd_valid`, `pix_valid`, `eof_evt` and `underflow_evt` are all 0.
- R2: Addresses must be word-aligned, with `end + 1` word-aligned. The first request of a buffer carries that buffer's start address. Each later request carries the previous address plus 4 × the previous beat count. While `mrd_valid` is high and `mrd_ready` is low, the address and beat count are held.
- R3: `burst_code` values 0, 1, 2, 3 and 4 request 1, 2, 4, 8 and 16 beats. Any code above 4 requests 16 beats.
- R4: The last request of a buffer is shortened to the number of words left, so its last beat reads the word at address `end - 3`.
- R5: With `dual_mode` = 0, every buffer fetched is buffer 0. With `dual_mode` = 1, buffers alternate, and the first buffer after reset is buffer 0.
- R6: `eof_evt[0]` (buffer 0) or `eof_evt[1]` (buffer 1) pulses for one cycle. The pulse comes only after every beat of that buffer has been returned.
- R7: The start and end addresses of a buffer are captured when that buffer starts. Rewriting them during its fetch has no effect on that fetch. The new values are used the next time that buffer starts.
- R8: A request is issued only when the FIFO free space, less the beats still in flight, is at least the request's beat count. The FIFO never holds more than `DEPTH` words.
- R9: Pixel words leave `pix_data` in the order their addresses were requested. Each word leaves on a cycle with `pix_valid` and `pix_ready` both high.
- R10: After reset, and after an underflow, `pix_valid` stays low until the FIFO holds at least min(2^`ready_thr`, `DEPTH`) words.
- R11: If `pix_ready` is high while output is enabled and the FIFO is empty, `underflow_evt` pulses once the following cycle and output is disabled. No event is raised while output is disabled.
- R12: When `fetch_en` falls, the buffer being fetched completes, and then no further requests are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en | input | 1 | Allows new buffers to start |
| dual_mode | input | 1 | 1 = alternate buffers, 0 = buffer 0 only |
| burst_code | input | 3 | Log2 of the burst length in beats |
| ready_thr | input | 3 | Log2 of the FIFO fill needed before output |
| fb0_base | input | AW | Buffer 0 start byte address |
| fb0_ceil | input | AW | Buffer 0 last byte address |
| fb1_base | input | AW | Buffer 1 start byte address |
| fb1_ceil | input | AW | Buffer 1 last byte address |
| mrd_valid | output | 1 | Read request valid |
| mrd_ready | input | 1 | Memory accepts the request |
| mrd_addr | output | AW | Request start address |
| mrd_beats | output | LENW | Request length in 32-bit beats |
| mresp_valid | input | 1 | Read data beat valid, in request order |
| mresp_data | input | DW | Read data beat |
| pix_valid | output | 1 | Pixel word available |
| pix_ready | input | 1 | Consumer takes a pixel word |
| pix_data | output | DW | Pixel word |
| eof_evt | output | 2 | One-cycle end-of-buffer pulse per buffer |
| underflow_evt | output | 1 | One-cycle FIFO underflow pulse |

## Verification
The bench runs four patterns.

- **Alternating mode with 4-beat bursts and a stalling memory.** This separates correct request sequencing and held requests from a design that drops or duplicates requests. It also rewrites buffer 0 mid-fetch, which exposes descriptors that are not captured at buffer start.
- **Single mode with an out-of-range burst code.** This tests the 16-beat clamp and confirms that buffer 1 is never touched.
- **Single-beat bursts across two short buffers.** This catches errors in the shortened final burst and in the order of end-of-buffer events.
- **A consumer that holds off while a threshold of 8 is set on a buffer larger than the FIFO.** This shows whether credit stalling, the output gate and underflow reporting each behave as required.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_LOAD  = 2'd1,
      FS_ISSUE = 2'd2,
      FS_DRAIN = 2'd3
   } fetch_state_e;

   // clamps a burst code to the largest supported log2 beat count
   function automatic int unsigned beat_log(input int unsigned code,
                                            input int unsigned max_log);
      return (code > max_log) ? max_log : code;
   endfunction

endpackage

// File: rtl/fbf_pix_fifo.sv
module fbf_pix_fifo #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 32,
   parameter int unsigned TW    = 3,
   parameter int unsigned PW    = $clog2(DEPTH),
   parameter int unsigned CW    = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          out_ready,
   input  logic [TW-1:0] thr_code,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic [CW-1:0] fill,
   output logic          underflow
);

   generate
      if ((1 << PW) != DEPTH) begin : g_bad_depth
         $error("fbf_pix_fifo: DEPTH must be a power of two");
      end
      if (PW < 1) begin : g_bad_small
         $error("fbf_pix_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [DW-1:0] mem_q [DEPTH];
   logic [PW-1:0] wr_q, rd_q;
   logic [CW-1:0] fill_q, level;
   logic          armed_q, live, pop, uf_now, uf_q;

   // fill level that opens the output gate
   always_comb begin
      level = CW'(DEPTH);
      if (32'(thr_code) < PW) level = CW'(1) << thr_code;
   end

   assign live      = armed_q || (fill_q >= level);
   assign out_valid = live && (fill_q != '0);
   assign out_data  = mem_q[rd_q];
   assign pop       = out_valid && out_ready;
   assign uf_now    = armed_q && out_ready && (fill_q == '0);
   assign fill      = fill_q;
   assign underflow = uf_q;

   always_ff @(posedge clk) begin
      if (push) mem_q[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= '0;
         rd_q    <= '0;
         fill_q  <= '0;
         armed_q <= 1'b0;
         uf_q    <= 1'b0;
      end else begin
         if (push) wr_q <= wr_q + PW'(1);
         if (pop)  rd_q <= rd_q + PW'(1);
         case ({push, pop})
            2'b10:   fill_q <= fill_q + CW'(1);
            2'b01:   fill_q <= fill_q - CW'(1);
            default: fill_q <= fill_q;
         endcase
         armed_q <= uf_now ? 1'b0 : live;
         uf_q    <= uf_now;
      end
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> ((fill_q != CW'(DEPTH)) || pop));

   assert_uf_disarms_R11: assert property (@(posedge clk) disable iff (!rst_n)
      uf_q |-> !armed_q);

endmodule

// File: rtl/fbf_fetch_seq.sv
module fbf_fetch_seq
   import fbf_pkg::*;
#(
   parameter int unsigned AW          = 32,
   parameter int unsigned BW          = 3,
   parameter int unsigned MAX_LOG2    = 4,
   parameter int unsigned LENW        = MAX_LOG2 + 1,
   parameter int unsigned CW          = 6,
   parameter int unsigned CREDIT_FULL = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            dual,
   input  logic [BW-1:0]   burst_code,
   input  logic [AW-1:0]   base0,
   input  logic [AW-1:0]   ceil0,
   input  logic [AW-1:0]   base1,
   input  logic [AW-1:0]   ceil1,
   input  logic [CW-1:0]   credit_free,
   input  logic            inflight_zero,
   output logic            req_valid,
   input  logic            req_ready,
   output logic [AW-1:0]   req_addr,
   output logic [LENW-1:0] req_len,
   output logic [1:0]      eof
);

   generate
      if ((1 << BW) <= MAX_LOG2) begin : g_bad_bw
         $error("fbf_fetch_seq: burst code too narrow for MAX_LOG2");
      end
      if (AW < 8) begin : g_bad_aw
         $error("fbf_fetch_seq: address width too small");
      end
   endgenerate

   fetch_state_e    st_q;
   logic [AW-1:0]   addr_q, ceil_q, words_left, burst_w, len_w;
   logic            cur_q, sel_q, sel_pick, hs;
   logic [1:0]      eof_q;
   logic [LENW-1:0] need;

   assign words_left = (ceil_q - addr_q + AW'(1)) >> 2;
   assign burst_w    = AW'(1) << beat_log(32'(burst_code), MAX_LOG2);
   assign len_w      = (words_left < burst_w) ? words_left : burst_w;
   assign req_len    = LENW'(len_w);
   assign req_addr   = addr_q;
   assign sel_pick   = dual ? cur_q : 1'b0;

   // credit policy variant: reserve the shortened burst or always a full one
   generate
      if (CREDIT_FULL != 0) begin : g_credit_full
         assign need = LENW'(burst_w);
      end else begin : g_credit_exact
         assign need = req_len;
      end
   endgenerate

   assign req_valid = (st_q == FS_ISSUE) && (32'(credit_free) >= 32'(need));
   assign hs        = req_valid && req_ready;
   assign eof       = eof_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= FS_IDLE;
         addr_q <= '0;
         ceil_q <= '0;
         cur_q  <= 1'b0;
         sel_q  <= 1'b0;
         eof_q  <= '0;
      end else begin
         eof_q <= '0;
         case (st_q)
            FS_IDLE: begin
               if (enable) st_q <= FS_LOAD;
            end
            FS_LOAD: begin
               sel_q  <= sel_pick;
               addr_q <= sel_pick ? base1 : base0;
               ceil_q <= sel_pick ? ceil1 : ceil0;
               st_q   <= FS_ISSUE;
            end
            FS_ISSUE: begin
               if (hs) begin
                  addr_q <= addr_q + (len_w << 2);
                  if (len_w == words_left) st_q <= FS_DRAIN;
               end
            end
            FS_DRAIN: begin
               if (inflight_zero) begin
                  eof_q <= sel_q ? 2'b10 : 2'b01;
                  cur_q <= dual ? ~sel_q : 1'b0;
                  st_q  <= enable ? FS_LOAD : FS_IDLE;
               end
            end
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

   assert_end_at_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_DRAIN && $past(st_q) == FS_ISSUE) |-> (addr_q == ceil_q + AW'(1)));

   assert_eof_after_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|eof_q) |-> ($past(st_q) == FS_DRAIN && $past(inflight_zero)));

   assert_single_buf0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_ISSUE && $past(st_q) == FS_LOAD && !$past(dual)) |-> !sel_q);

endmodule

// File: rtl/pingpong_fb_fetch.sv
module pingpong_fb_fetch #(
   parameter int unsigned AW          = 32,
   parameter int unsigned DW          = 32,
   parameter int unsigned DEPTH       = 32,
   parameter int unsigned MAX_LOG2    = 4,
   parameter int unsigned CREDIT_FULL = 0,
   parameter int unsigned LENW        = MAX_LOG2 + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fetch_en,
   input  logic            dual_mode,
   input  logic [2:0]      burst_code,
   input  logic [2:0]      ready_thr,
   input  logic [AW-1:0]   fb0_base,
   input  logic [AW-1:0]   fb0_ceil,
   input  logic [AW-1:0]   fb1_base,
   input  logic [AW-1:0]   fb1_ceil,
   output logic            mrd_valid,
   input  logic            mrd_ready,
   output logic [AW-1:0]   mrd_addr,
   output logic [LENW-1:0] mrd_beats,
   input  logic            mresp_valid,
   input  logic [DW-1:0]   mresp_data,
   output logic            pix_valid,
   input  logic            pix_ready,
   output logic [DW-1:0]   pix_data,
   output logic [1:0]      eof_evt,
   output logic            underflow_evt
);

   localparam int unsigned PW = $clog2(DEPTH);
   localparam int unsigned CW = PW + 1;

   generate
      if (DEPTH < (1 << MAX_LOG2)) begin : g_bad_fit
         $error("pingpong_fb_fetch: FIFO smaller than the largest burst");
      end
      if (LENW > CW) begin : g_bad_lenw
         $error("pingpong_fb_fetch: beat count wider than credit counter");
      end
   endgenerate

   logic [CW-1:0] pending_q, fill, credit_free;
   logic          hs;

   assign hs          = mrd_valid && mrd_ready;
   assign credit_free = CW'(DEPTH) - fill - pending_q;

   // beats requested but not yet returned
   always_ff @(posedge clk) begin
      if (!rst_n) pending_q <= '0;
      else        pending_q <= pending_q + (hs ? CW'(mrd_beats) : '0)
                                         - (mresp_valid ? CW'(1) : '0);
   end

   fbf_fetch_seq #(
      .AW(AW), .BW(3), .MAX_LOG2(MAX_LOG2), .LENW(LENW),
      .CW(CW), .CREDIT_FULL(CREDIT_FULL)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (fetch_en),
      .dual         (dual_mode),
      .burst_code   (burst_code),
      .base0        (fb0_base),
      .ceil0        (fb0_ceil),
      .base1        (fb1_base),
      .ceil1        (fb1_ceil),
      .credit_free  (credit_free),
      .inflight_zero(pending_q == '0),
      .req_valid    (mrd_valid),
      .req_ready    (mrd_ready),
      .req_addr     (mrd_addr),
      .req_len      (mrd_beats),
      .eof          (eof_evt)
   );

   fbf_pix_fifo #(
      .DW(DW), .DEPTH(DEPTH), .TW(3), .PW(PW), .CW(CW)
   ) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (mresp_valid),
      .push_data(mresp_data),
      .out_ready(pix_ready),
      .thr_code (ready_thr),
      .out_valid(pix_valid),
      .out_data (pix_data),
      .fill     (fill),
      .underflow(underflow_evt)
   );

   assert_credit_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(fill) + 32'(pending_q)) <= 32'(DEPTH));

   assert_resp_expected_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mresp_valid |-> (pending_q != '0));

endmodule

// File: tb/pingpong_fb_fetch_bench.sv
module pingpong_fb_fetch_bench;

   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, fetch_en, dual_mode;
   logic [2:0]  burst_code, ready_thr;
   logic [31:0] fb0_base, fb0_ceil, fb1_base, fb1_ceil;
   logic        mrd_valid, mrd_ready;
   logic [31:0] mrd_addr;
   logic [4:0]  mrd_beats;
   logic        mresp_valid;
   logic [31:0] mresp_data;
   logic        pix_valid, pix_ready;
   logic [31:0] pix_data;
   logic [1:0]  eof_evt;
   logic        underflow_evt;

   pingpong_fb_fetch #(.DEPTH(DEPTH)) u_pingpong_fb_fetch (
      .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .dual_mode(dual_mode),
      .burst_code(burst_code), .ready_thr(ready_thr),
      .fb0_base(fb0_base), .fb0_ceil(fb0_ceil), .fb1_base(fb1_base), .fb1_ceil(fb1_ceil),
      .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr), .mrd_beats(mrd_beats),
      .mresp_valid(mresp_valid), .mresp_data(mresp_data),
      .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
      .eof_evt(eof_evt), .underflow_evt(underflow_evt)
   );

   int n_cmp = 0, n_bad = 0;
   logic [31:0] exp_addr[$];
   int          exp_len[$];
   logic [31:0] exp_pix[$];
   int          exp_eof[$];
   logic [31:0] mem_addr[$];
   int          mem_due[$];
   int cyc = 0, req_seen = 0, words_req = 0, beats_driven = 0, uf_count = 0;
   int rdy_mode = 0, cons_mode = 0;

   function automatic logic [31:0] pat(input logic [31:0] a);
      return a ^ 32'h5A5A_0000;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // driver side of the scoreboard: expected requests, pixels and events
   task automatic plan_buf(input int sel, input logic [31:0] base,
                           input logic [31:0] ceil, input int beats);
      logic [31:0] a;
      int left, n;
      a = base;
      left = int'((ceil - base + 1) >> 2);
      while (left > 0) begin
         n = (left < beats) ? left : beats;
         exp_addr.push_back(a);
         exp_len.push_back(n);
         for (int i = 0; i < n; i++) exp_pix.push_back(pat(a + 32'(4 * i)));
         a = a + 32'(4 * n);
         left = left - n;
      end
      exp_eof.push_back(sel);
   endtask

   // memory model and request monitor
   initial begin
      logic [31:0] ea;
      int en;
      mrd_ready = 1'b0; mresp_valid = 1'b0; mresp_data = '0;
      forever begin
         @(negedge clk);
         cyc++;
         mrd_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
         if (rst_n && mrd_valid && mrd_ready) begin
            req_seen++;
            words_req += int'(mrd_beats);
            if (exp_addr.size() == 0) chk("R12 unexpected request", 1, 0);
            else begin
               ea = exp_addr.pop_front();
               en = exp_len.pop_front();
               chk("R2 request address", mrd_addr, ea);
               chk("R3 R4 request beats", mrd_beats, en);
            end
            for (int i = 0; i < int'(mrd_beats); i++) begin
               mem_addr.push_back(mrd_addr + 32'(4 * i));
               mem_due.push_back(cyc + 3);
            end
         end
         if (mem_addr.size() != 0 && mem_due[0] <= cyc) begin
            mresp_valid = 1'b1;
            mresp_data  = pat(mem_addr.pop_front());
            void'(mem_due.pop_front());
            beats_driven++;
         end else begin
            mresp_valid = 1'b0;
         end
      end
   end

   // consumer and event monitor
   initial begin
      logic [31:0] ep;
      int eb;
      pix_ready = 1'b0;
      forever begin
         @(negedge clk);
         if (underflow_evt) uf_count++;
         if (eof_evt != 2'b00) begin
            chk("R6 eof only after last beat returned", mem_addr.size(), 0);
            if (exp_eof.size() == 0) chk("R6 unexpected eof", eof_evt, 0);
            else begin
               eb = exp_eof.pop_front();
               chk("R5 R6 eof buffer", eof_evt, (eb == 1) ? 2'b10 : 2'b01);
            end
         end
         pix_ready = (cons_mode == 1) ? 1'b1 : (cons_mode == 2) ? ((cyc % 4) != 3) : 1'b0;
         if (pix_valid && pix_ready) begin
            if (exp_pix.size() == 0) chk("R9 unexpected pixel", pix_data, 0);
            else begin
               ep = exp_pix.pop_front();
               chk("R9 pixel order", pix_data, ep);
            end
         end
      end
   end

   task automatic finish_phase();
      wait (exp_eof.size() == 0 && exp_pix.size() == 0);
      repeat (6) @(posedge clk);
      #2;
      chk("R12 idle after enable drop", mrd_valid, 0);
      chk("R12 no pending expected requests", exp_addr.size(), 0);
   endtask

   initial begin
      int start, w0, d0, u0, u1, bad;
      rst_n = 1'b0; fetch_en = 1'b0; dual_mode = 1'b0;
      burst_code = 3'd0; ready_thr = 3'd0;
      fb0_base = '0; fb0_ceil = '0; fb1_base = '0; fb1_ceil = '0;
      repeat (4) @(posedge clk);
      #2;
      chk("R1 no request in reset", mrd_valid, 0);
      chk("R1 no pixel in reset", pix_valid, 0);
      chk("R1 no eof in reset", eof_evt, 0);
      chk("R1 no underflow in reset", underflow_evt, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 idle while disabled", mrd_valid, 0);

      // alternating mode, 4-beat bursts, stalling memory, mid-fetch rewrite
      @(negedge clk);
      rdy_mode = 1; cons_mode = 2; dual_mode = 1'b1; burst_code = 3'd2;
      fb0_base = 32'h1000; fb0_ceil = 32'h1027;
      fb1_base = 32'h2000; fb1_ceil = 32'h203F;
      plan_buf(0, 32'h1000, 32'h1027, 4);
      plan_buf(1, 32'h2000, 32'h203F, 4);
      plan_buf(0, 32'h3000, 32'h300B, 4);   // R7: rewritten values used next time
      start = req_seen;
      fetch_en = 1'b1;
      wait (req_seen == start + 1);
      fb0_base = 32'h3000; fb0_ceil = 32'h300B;
      wait (req_seen == start + 8);
      fetch_en = 1'b0;
      finish_phase();

      // single mode with out-of-range burst code (clamped to 16)
      @(negedge clk);
      rdy_mode = 0; dual_mode = 1'b0; burst_code = 3'd7;
      fb0_base = 32'h4000; fb0_ceil = 32'h407F;
      fb1_base = 32'h9000; fb1_ceil = 32'h90FF;
      plan_buf(0, 32'h4000, 32'h407F, 16);
      plan_buf(0, 32'h4000, 32'h407F, 16);
      start = req_seen;
      fetch_en = 1'b1;
      wait (req_seen == start + 4);
      fetch_en = 1'b0;
      finish_phase();

      // single-beat bursts, alternating, two short buffers
      @(negedge clk);
      rdy_mode = 1; dual_mode = 1'b1; burst_code = 3'd0;
      fb0_base = 32'h5000; fb0_ceil = 32'h500B;
      fb1_base = 32'h6000; fb1_ceil = 32'h6007;
      plan_buf(0, 32'h5000, 32'h500B, 1);
      plan_buf(1, 32'h6000, 32'h6007, 1);
      start = req_seen;
      fetch_en = 1'b1;
      wait (req_seen == start + 5);
      fetch_en = 1'b0;
      finish_phase();

      // threshold gate, credit stall and underflow
      @(negedge clk);
      rdy_mode = 0; cons_mode = 1;
      repeat (3) @(negedge clk);
      cons_mode = 0;
      repeat (3) @(negedge clk);
      u0 = uf_count;
      cons_mode = 1;
      repeat (3) @(negedge clk);
      cons_mode = 0;
      repeat (3) @(negedge clk);
      chk("R11 no underflow while disarmed", uf_count, u0);

      dual_mode = 1'b0; burst_code = 3'd3; ready_thr = 3'd3;
      fb0_base = 32'h7000; fb0_ceil = 32'h709F;
      plan_buf(0, 32'h7000, 32'h709F, 8);
      w0 = words_req; d0 = beats_driven; start = req_seen;
      fetch_en = 1'b1;
      bad = 0;
      repeat (80) begin
         @(posedge clk);
         #2;
         if (pix_valid !== ((beats_driven - d0) >= 8)) bad++;
      end
      chk("R10 output gated until fill reaches 8", bad, 0);
      chk("R8 words requested with no room", words_req - w0, DEPTH);
      chk("R10 output open once filled", pix_valid, 1);
      @(negedge clk);
      u1 = uf_count;
      cons_mode = 1;
      wait (req_seen == start + 5);
      fetch_en = 1'b0;
      finish_phase();
      repeat (4) @(posedge clk);
      #2;
      chk("R11 one underflow after draining", uf_count - u1, 1);
      chk("R11 output closed after underflow", pix_valid, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule